// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a one-way first-in first-out buffer that carries 18-bit words from a producer clocked by `wr_clk` to a consumer clocked by `rd_clk`. The two clocks have no fixed relation. Each side moves one word per rising edge of its clock while its active-low enable is held low. The depth is a parameter and may be 256 or 512 words.

Four active-low level flags report the state of the buffer. `empty_n` and `aempty_n` belong to the read domain. `full_n` and `afull_n` belong to the write domain. Each almost threshold is a run-time offset that the producer writes through a small configuration port in the write domain. Each side learns the other side's pointer through a Gray-coded synchronizer. As a result, a flag can go active at once because of the local side's own action, but it goes inactive only after the crossing latency has passed. A single low-active reset returns the pointers, the flags and both offsets to their initial state.

Top module: `pflag_dc_fifo`

## Requirements
- R1: While `rst_n` is low and after it is released, `empty_n` and `aempty_n` read 0 and `full_n` and `afull_n` read 1. Both offset registers hold 8. `rd_data` reads 0.
- R2: A word is accepted on a rising `wr_clk` edge only when `wr_en_n` is 0 and `full_n` is 1. A word is removed on a rising `rd_clk` edge only when `rd_en_n` is 0 and `empty_n` is 1. An enable held at 1 moves nothing.
- R3: A write attempted while `full_n` is 0 is dropped. It neither stores a word nor disturbs the stored words.
- R4: A read attempted while `empty_n` is 0 is dropped. It leaves `rd_data` unchanged and leaves the buffer empty.
- R5: Words leave in the order they were accepted. The word appears on `rd_data` after the `rd_clk` edge that accepts the read, and it holds until the next accepted read.
- R6: Once both sides are idle for a few cycles, `empty_n` is 0 exactly when no word is stored, and `full_n` is 0 exactly when DEPTH words are stored.
- R7: Once settled, `aempty_n` is 0 when the stored count is less than or equal to the almost-empty offset, and 1 when the count is above it.
- R8: Once settled, `afull_n` is 0 when the stored count is greater than DEPTH minus the almost-full offset, and 1 otherwise.
- R9: On a rising `wr_clk` edge with `ofs_we` at 1, `ofs_data` is loaded into the almost-empty offset when `ofs_sel` is 0, or into the almost-full offset when `ofs_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| rd_clk | input | 1 | Consumer clock |
| rst_n | input | 1 | Asynchronous reset for both domains, active low |
| wr_en_n | input | 1 | Write request, active low |
| wr_data | input | DATA_W | Word to store |
| full_n | output | 1 | Low when no room is left (write domain) |
| afull_n | output | 1 | Low when the fill is above DEPTH minus the almost-full offset (write domain) |
| ofs_we | input | 1 | Offset register load strobe |
| ofs_sel | input | 1 | Target of the load: 0 selects almost-empty, 1 selects almost-full |
| ofs_data | input | log2(DEPTH)+1 | Offset value to load |
| rd_en_n | input | 1 | Read request, active low |
| rd_data | output | DATA_W | Registered output word |
| empty_n | output | 1 | Low when no word is stored (read domain) |
| aempty_n | output | 1 | Low when the fill is at or below the almost-empty offset (read domain) |

## Verification
The bench first pushes against both ends. It keeps writing into a full buffer with a marker word, then drains it. A design that let the write through would wrap its pointer, give back the marker or a stale word, and never report empty again. It also reads from an empty buffer: a design that moved its read pointer there would report data that was never written. Each threshold is checked on both sides of its boundary, at the default offsets, at programmed offsets and at random ones, which exposes an off-by-one comparison or swapped offset selection. A second reset confirms that the offsets fall back to 8. A long random phase with both sides running at once checks every word in order, which catches a pointer that is mis-encoded in Gray code or sampled in the wrong domain.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
   // Destination of an offset register load
   typedef enum logic {
      OFS_AEMPTY = 1'b0,
      OFS_AFULL  = 1'b1
   } ofs_sel_e;

   localparam int MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
   parameter int W      = 9,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < dcf_pkg::MIN_SYNC_STAGES) begin : g_bad_stages
      $error("dcf_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
   parameter int DW = 18,
   parameter int AW = 8
) (
   input  logic          wr_clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= mem[rd_addr];
   end

   // Output word holds between accepted reads
   p_rd_hold_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/dcf_wr_ctl.sv
`timescale 1ns/1ps
module dcf_wr_ctl import dcf_pkg::*; #(
   parameter int AW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter int OFS_RST     = 8
) (
   input  logic          wr_clk,
   input  logic          rst_n,
   input  logic          wr_en_n,
   input  logic          ofs_we,
   input  logic          ofs_sel,
   input  logic [AW:0]   ofs_data,
   input  logic [AW:0]   rd_gray_x,
   output logic          wr_push,
   output logic [AW-1:0] wr_addr,
   output logic [AW:0]   wr_gray,
   output logic [AW:0]   ae_off,
   output logic          full_n,
   output logic          afull_n
);
   localparam int PW = AW + 1;
   localparam int DEPTH = 1 << AW;
   localparam logic [PW:0]   DEPTH_X  = (PW+1)'(DEPTH);
   localparam logic [PW-1:0] OFS_INIT = PW'(OFS_RST);

   logic [PW-1:0] wr_bin, wr_bin_nxt, rd_gray_s, rd_bin, fill, af_off;
   logic [PW:0]   af_sum;

   dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rd_sync (
      .clk(wr_clk), .rst_n(rst_n), .d(rd_gray_x), .q(rd_gray_s)
   );

   always_comb begin
      rd_bin[PW-1] = rd_gray_s[PW-1];
      for (int i = PW-2; i >= 0; i--) rd_bin[i] = rd_bin[i+1] ^ rd_gray_s[i];
   end

   assign wr_push    = !wr_en_n && full_n;
   assign wr_bin_nxt = wr_bin + PW'(wr_push);
   assign wr_addr    = wr_bin[AW-1:0];

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_bin  <= '0;
         wr_gray <= '0;
      end else begin
         wr_bin  <= wr_bin_nxt;
         wr_gray <= wr_bin_nxt ^ (wr_bin_nxt >> 1);
      end
   end

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         ae_off <= OFS_INIT;
         af_off <= OFS_INIT;
      end else if (ofs_we) begin
         if (ofs_sel_e'(ofs_sel) == OFS_AFULL) af_off <= ofs_data;
         else                                  ae_off <= ofs_data;
      end
   end

   assign fill    = wr_bin - rd_bin;
   assign af_sum  = {1'b0, fill} + {1'b0, af_off};
   assign full_n  = (fill != DEPTH_X[PW-1:0]);
   assign afull_n = (af_sum <= DEPTH_X);

   p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (!full_n && !wr_en_n) |=> $stable(wr_bin));
   p_wr_step_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (!wr_en_n && full_n) |=> (wr_bin == $past(wr_bin) + 1'b1));
   p_wr_idle_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
      wr_en_n |=> $stable(wr_bin));
   p_gray_step_r6: assert property (@(posedge wr_clk) disable iff (!rst_n)
      1'b1 |=> ($countones(wr_gray ^ $past(wr_gray)) <= 1));
   p_fill_bound_r6: assert property (@(posedge wr_clk) disable iff (!rst_n)
      fill <= DEPTH_X[PW-1:0]);
   p_full_in_afull_r8: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (!full_n && af_off != '0) |-> !afull_n);
endmodule

// File: rtl/dcf_rd_ctl.sv
`timescale 1ns/1ps
module dcf_rd_ctl #(
   parameter int AW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          rd_clk,
   input  logic          rst_n,
   input  logic          rd_en_n,
   input  logic [AW:0]   wr_gray_x,
   input  logic [AW:0]   ae_off,
   output logic          rd_pop,
   output logic [AW-1:0] rd_addr,
   output logic [AW:0]   rd_gray,
   output logic          empty_n,
   output logic          aempty_n
);
   localparam int PW = AW + 1;
   localparam int DEPTH = 1 << AW;

   logic [PW-1:0] rd_bin, rd_bin_nxt, wr_gray_s, wr_bin, fill;

   dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wr_sync (
      .clk(rd_clk), .rst_n(rst_n), .d(wr_gray_x), .q(wr_gray_s)
   );

   always_comb begin
      wr_bin[PW-1] = wr_gray_s[PW-1];
      for (int i = PW-2; i >= 0; i--) wr_bin[i] = wr_bin[i+1] ^ wr_gray_s[i];
   end

   assign rd_pop     = !rd_en_n && empty_n;
   assign rd_bin_nxt = rd_bin + PW'(rd_pop);
   assign rd_addr    = rd_bin[AW-1:0];

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_bin  <= '0;
         rd_gray <= '0;
      end else begin
         rd_bin  <= rd_bin_nxt;
         rd_gray <= rd_bin_nxt ^ (rd_bin_nxt >> 1);
      end
   end

   // Offset crosses from the write domain and is treated as quasi-static
   assign fill     = wr_bin - rd_bin;
   assign empty_n  = (fill != '0);
   assign aempty_n = (fill > ae_off);

   p_no_underflow_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!empty_n && !rd_en_n) |=> $stable(rd_bin));
   p_rd_step_r2: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!rd_en_n && empty_n) |=> (rd_bin == $past(rd_bin) + 1'b1));
   p_rd_idle_r2: assert property (@(posedge rd_clk) disable iff (!rst_n)
      rd_en_n |=> $stable(rd_bin));
   p_fill_bound_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
      fill <= PW'(DEPTH));
   p_empty_in_aempty_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !empty_n |-> !aempty_n);
endmodule

// File: rtl/pflag_dc_fifo.sv
`timescale 1ns/1ps
module pflag_dc_fifo #(
   parameter int DATA_W      = 18,
   parameter int DEPTH       = 256,
   parameter int SYNC_STAGES = 2,
   parameter int OFS_RST     = 8
) (
   input  logic                   wr_clk,
   input  logic                   rd_clk,
   input  logic                   rst_n,
   input  logic                   wr_en_n,
   input  logic [DATA_W-1:0]      wr_data,
   output logic                   full_n,
   output logic                   afull_n,
   input  logic                   ofs_we,
   input  logic                   ofs_sel,
   input  logic [$clog2(DEPTH):0] ofs_data,
   input  logic                   rd_en_n,
   output logic [DATA_W-1:0]      rd_data,
   output logic                   empty_n,
   output logic                   aempty_n
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   if (DEPTH != 256 && DEPTH != 512) begin : g_bad_depth
      $error("pflag_dc_fifo: DEPTH must be 256 or 512");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("pflag_dc_fifo: DATA_W must be positive");
   end
   if (OFS_RST < 0 || OFS_RST > DEPTH) begin : g_bad_ofs
      $error("pflag_dc_fifo: OFS_RST must lie in 0..DEPTH");
   end

   logic          wr_push, rd_pop;
   logic [AW-1:0] wr_addr, rd_addr;
   logic [PW-1:0] wr_gray, rd_gray, ae_off;

   dcf_wr_ctl #(.AW(AW), .SYNC_STAGES(SYNC_STAGES), .OFS_RST(OFS_RST)) u_wr (
      .wr_clk(wr_clk), .rst_n(rst_n), .wr_en_n(wr_en_n),
      .ofs_we(ofs_we), .ofs_sel(ofs_sel), .ofs_data(ofs_data),
      .rd_gray_x(rd_gray), .wr_push(wr_push), .wr_addr(wr_addr),
      .wr_gray(wr_gray), .ae_off(ae_off), .full_n(full_n), .afull_n(afull_n)
   );

   dcf_rd_ctl #(.AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_rd (
      .rd_clk(rd_clk), .rst_n(rst_n), .rd_en_n(rd_en_n),
      .wr_gray_x(wr_gray), .ae_off(ae_off), .rd_pop(rd_pop),
      .rd_addr(rd_addr), .rd_gray(rd_gray), .empty_n(empty_n), .aempty_n(aempty_n)
   );

   dcf_ram #(.DW(DATA_W), .AW(AW)) u_ram (
      .wr_clk(wr_clk), .wr_en(wr_push), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_clk(rd_clk), .rst_n(rst_n), .rd_en(rd_pop), .rd_addr(rd_addr),
      .rd_data(rd_data)
   );

   // Reset state of the flags
   p_rst_flags_r1: assert property (@(posedge wr_clk)
      !rst_n |-> (full_n && afull_n && !empty_n && !aempty_n));
endmodule

// File: tb/pflag_dc_fifo_test.sv
`timescale 1ns/1ps
module pflag_dc_fifo_test;
   localparam int DW    = 18;
   localparam int DEPTH = 256;
   localparam int OW    = $clog2(DEPTH) + 1;

   logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
   logic wr_en_n = 1'b1, rd_en_n = 1'b1, ofs_we = 1'b0, ofs_sel = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [OW-1:0] ofs_data = '0;
   logic [DW-1:0] rd_data;
   logic full_n, afull_n, empty_n, aempty_n;

   always #2   wr_clk = ~wr_clk;
   always #3.5 rd_clk = ~rd_clk;

   pflag_dc_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
      .wr_en_n(wr_en_n), .wr_data(wr_data), .full_n(full_n), .afull_n(afull_n),
      .ofs_we(ofs_we), .ofs_sel(ofs_sel), .ofs_data(ofs_data),
      .rd_en_n(rd_en_n), .rd_data(rd_data), .empty_n(empty_n), .aempty_n(aempty_n)
   );

   int n_chk = 0, n_fail = 0;
   int ae_o = 8, af_o = 8;
   logic [DW-1:0] q[$];
   logic [DW-1:0] next_val = 1;
   logic [DW-1:0] pend_exp;
   bit pend = 0, done = 0;

   task automatic check(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_ae_n(int n, int o); return (n > o) ? 1 : 0; endfunction
   function automatic int exp_af_n(int n, int o); return (n > DEPTH - o) ? 0 : 1; endfunction

   task automatic wr_cycle(bit en, logic [DW-1:0] d);
      @(negedge wr_clk);
      if (en && full_n) q.push_back(d);
      wr_en_n = !en;
      wr_data = d;
   endtask

   task automatic rd_cycle(bit en);
      @(negedge rd_clk);
      if (pend) check("R5", "read word", int'(rd_data), int'(pend_exp));
      pend = 0;
      if (en && empty_n) begin
         if (q.size() == 0) check("R6", "empty_n with nothing stored", 1, 0);
         else begin
            pend_exp = q.pop_front();
            pend = 1;
         end
      end
      rd_en_n = !en;
   endtask

   task automatic put(int n);
      repeat (n) begin
         wr_cycle(1'b1, next_val);
         next_val++;
      end
      wr_cycle(1'b0, '0);
   endtask

   task automatic drain();
      int g = 0;
      while (q.size() > 0 && g < 4*DEPTH) begin
         rd_cycle(1'b1);
         g++;
      end
      rd_cycle(1'b0);
      rd_cycle(1'b0);
      check("R6", "words left after drain", q.size(), 0);
   endtask

   task automatic settle();
      repeat (6) @(negedge wr_clk);
      repeat (6) @(negedge rd_clk);
   endtask

   task automatic flags(string req);
      int n;
      settle();
      n = q.size();
      check(req, "empty_n",  int'(empty_n),  (n != 0) ? 1 : 0);
      check(req, "aempty_n", int'(aempty_n), exp_ae_n(n, ae_o));
      check(req, "full_n",   int'(full_n),   (n != DEPTH) ? 1 : 0);
      check(req, "afull_n",  int'(afull_n),  exp_af_n(n, af_o));
   endtask

   task automatic set_ofs(bit sel, int v);
      @(negedge wr_clk);
      ofs_we = 1'b1; ofs_sel = sel; ofs_data = OW'(v);
      @(negedge wr_clk);
      ofs_we = 1'b0;
      if (sel) af_o = v; else ae_o = v;
   endtask

   task automatic do_reset();
      @(negedge wr_clk);
      rst_n = 1'b0; wr_en_n = 1'b1; rd_en_n = 1'b1; ofs_we = 1'b0;
      q.delete(); pend = 0; ae_o = 8; af_o = 8;
      repeat (3) @(negedge rd_clk);
      #0.5 rst_n = 1'b1;
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (4) @(negedge rd_clk);
      #0.5 rst_n = 1'b1;

      // R1: reset state
      flags("R1");
      check("R1", "rd_data after reset", int'(rd_data), 0);

      // R4: reads from an empty buffer are dropped
      repeat (3) rd_cycle(1'b1);
      rd_cycle(1'b0);
      flags("R4");
      check("R4", "rd_data after empty reads", int'(rd_data), 0);
      put(1);
      flags("R6");
      drain();
      flags("R4");

      // R7: almost-empty boundary at the default offset
      put(8);  flags("R7");
      put(1);  flags("R7");
      drain(); flags("R7");

      // R8, R6, R3: almost-full boundary, full, writes into a full buffer
      put(DEPTH-8); flags("R8");
      put(1);       flags("R8");
      put(7);       flags("R6");
      repeat (5) wr_cycle(1'b1, '1);
      wr_cycle(1'b0, '0);
      flags("R3");
      check("R3", "stored count while full", q.size(), DEPTH);
      drain(); flags("R3");

      // R9: programmed offsets
      set_ofs(1'b0, 20);
      set_ofs(1'b1, 30);
      put(20);            flags("R9");
      put(1);             flags("R9");
      put(DEPTH-30-21);   flags("R9");
      put(1);             flags("R9");
      drain();            flags("R9");

      // R1: offsets return to 8 on reset
      do_reset();
      flags("R1");
      put(9);
      flags("R1");
      check("R1", "aempty_n with 9 words after reset", int'(aempty_n), 1);
      drain();

      // R7/R8: random offsets and fill levels
      for (int k = 0; k < 4; k++) begin
         set_ofs(1'b0, int'($urandom % 60));
         set_ofs(1'b1, int'($urandom % 60));
         put(int'($urandom % (DEPTH + 1)));
         flags("R8");
         drain();
         flags("R7");
      end

      // R2/R5: both sides active together
      fork
         begin
            for (int i = 0; i < 1500; i++) begin
               bit e;
               e = ($urandom % 10) < 6;
               wr_cycle(e, DW'($urandom));
            end
            wr_cycle(1'b0, '0);
         end
         begin
            for (int i = 0; i < 1000; i++) rd_cycle(bit'($urandom % 2));
            rd_cycle(1'b0);
         end
      join
      drain();
      flags("R2");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R2 watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule